// File: doc/BRIEF.md
# Protection Entry Configuration Register with Write Legalization

This block is a machine-mode configuration register that holds eight 8-bit memory protection entry configurations packed into one 64-bit word. Software writes the full word with a write strobe. Each byte is filtered on its own before it is committed, so an illegal value in one byte never blocks a legal value in another. Reading returns the committed word.

A rejected byte keeps its previous contents. A byte is rejected when its stored lock bit is already set, when the new value asks for write without read, or when it selects the four-byte aligned matching mode on a build whose granularity parameter is 2 or more. A narrow build (32-bit register width) keeps only the lower four bytes.

A small evaluation port takes an entry index, an access kind and a privilege level. It reports whether that access would fault under the entry's stored permission bits. Address range matching is not part of this block.

Top module: `pmpc_cfg_reg`

## Requirements
- R1: While `rst` is high at a clock edge, every byte clears to 0x00, which means unlocked with the matching mode off. A locked entry is cleared as well.
- R2: On a clock edge with `wr_en` high, an unlocked byte in a writable lane whose new value is legal takes the new value, apart from the bits named in R3.
- R3: Bits 6:5 of each byte are reserved. They always read 0, whatever value is written to them.
- R4: A new byte with bit 0 (read) equal to 0 and bit 1 (write) equal to 1 is rejected, and that byte keeps its old value.
- R5: Each byte is legalized on its own. A rejected byte does not stop the other bytes of the same write from being updated.
- R6: Bits 4:3 hold the matching mode: 0 off, 1 top-of-range, 2 four-byte aligned, 3 power-of-two aligned. When `GRAN` is 2 or more, a write selecting mode 2 is rejected. When `GRAN` is below 2, mode 2 is accepted.
- R7: While a byte's stored bit 7 (lock) is 1, writes leave the whole byte unchanged, and the lock cannot be cleared by a write.
- R8: With `XLEN` = 32, bytes 4 to 7 (`rd_data[63:32]`) are never written and always read 0.
- R9: For a non-machine privilege, `chk_fault` is 1 in each of these cases: a load (`chk_acc`=0) with bit 0 clear, a store or atomic (`chk_acc`=1) with bit 1 clear, or an instruction fetch (`chk_acc`=2) with bit 2 clear. Access code 3 always faults.
- R10: For machine privilege (`chk_priv`=3), an unlocked entry never faults. A locked entry is checked exactly as in R9.
- R11: A legal write appears on `rd_data` after the clock edge that captures it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | 64 | Requested new word, one byte per entry |
| rd_data | output | 64 | Committed configuration word |
| chk_idx | input | 3 | Entry index for the permission query |
| chk_acc | input | 2 | Access kind: 0 load, 1 store/atomic, 2 fetch, 3 reserved |
| chk_priv | input | 2 | Privilege of the access; 3 is machine |
| chk_fault | output | 1 | The queried access would fault |

## Verification
The assertions check several invariants on every cycle: reserved bits read zero, no byte ever holds the write-without-read pair, the forbidden matching mode never appears, narrow builds keep their upper half clear, a locked byte stays stable, a clean write lands one edge later, and machine accesses to unlocked entries never fault. Some behaviours can only be shown by the bench's scenarios. These include a rejected byte sitting next to accepted bytes in one word, a lock that survives an attempt to clear it, and the difference between the two granularity settings on the same write. They also include the fault decision for each access kind against a concrete stored word. Both a wide build with coarse granularity and a narrow build with fine granularity are driven in parallel and compared with a behavioural model on every clock.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

    localparam int ENT_W = 8;

    // field positions inside one entry byte
    localparam int B_R    = 0;
    localparam int B_W    = 1;
    localparam int B_X    = 2;
    localparam int B_LOCK = 7;

    // reserved bits 6:5 are dropped on every commit
    localparam logic [ENT_W-1:0] KEEP_MASK = 8'h9F;

    typedef enum logic [1:0] {
        MM_OFF   = 2'd0,
        MM_TOR   = 2'd1,
        MM_NA4   = 2'd2,
        MM_NAPOT = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PRV_U   = 2'd0,
        PRV_S   = 2'd1,
        PRV_RSV = 2'd2,
        PRV_M   = 2'd3
    } priv_e;

    typedef struct packed {
        logic        lock;
        logic [1:0]  rsvd;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } entry_t;

    function automatic logic perm_pair_bad(entry_t e);
        return (!e.r) && e.w;
    endfunction

    function automatic logic mode_bad(entry_t e, int gran);
        return (gran >= 2) && (e.mode == MM_NA4);
    endfunction

endpackage

// File: rtl/pmpc_legalize.sv
module pmpc_legalize
    import pmpc_pkg::*;
#(
    parameter int GRAN = 2
) (
    input  logic   wr_ok,
    input  logic   we,
    input  entry_t cur,
    input  entry_t req,
    output entry_t nxt
);
    logic accept;

    always_comb begin
        accept = wr_ok && we && !cur.lock
                 && !perm_pair_bad(req) && !mode_bad(req, GRAN);
        nxt    = accept ? entry_t'(req & KEEP_MASK) : cur;
    end
endmodule

// File: rtl/pmpc_store.sv
module pmpc_store #(
    parameter int NENT  = 8,
    parameter int ENT_W = 8,
    localparam int WORD_W = NENT * ENT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] nxt,
    output logic [WORD_W-1:0] q
);
    for (genvar i = 0; i < NENT; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) q[i*ENT_W +: ENT_W] <= '0;
            else     q[i*ENT_W +: ENT_W] <= nxt[i*ENT_W +: ENT_W];
        end
    end
endmodule

// File: rtl/pmpc_perm.sv
module pmpc_perm
    import pmpc_pkg::*;
#(
    parameter int NENT = 8,
    localparam int IDX_W = $clog2(NENT)
) (
    input  logic [NENT-1:0]  lock_v,
    input  logic [NENT-1:0]  r_v,
    input  logic [NENT-1:0]  w_v,
    input  logic [NENT-1:0]  x_v,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       acc,
    input  logic [1:0]       priv,
    output logic             fault
);
    logic      l_s, r_s, w_s, x_s, deny;
    acc_kind_e kind;

    always_comb begin
        l_s  = lock_v[idx];
        r_s  = r_v[idx];
        w_s  = w_v[idx];
        x_s  = x_v[idx];
        kind = acc_kind_e'(acc);
        unique case (kind)
            ACC_LOAD:  deny = !r_s;
            ACC_STORE: deny = !w_s;
            ACC_FETCH: deny = !x_s;
            default:   deny = 1'b1;
        endcase
        if ((priv == PRV_M) && !l_s) fault = 1'b0;
        else                         fault = deny;
    end
endmodule

// File: rtl/pmpc_cfg_reg.sv
module pmpc_cfg_reg
    import pmpc_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int GRAN = 2,
    parameter int NENT = 8,
    localparam int WORD_W = NENT * ENT_W,
    localparam int IDX_W  = $clog2(NENT),
    localparam int ACTIVE = (XLEN == 32) ? NENT / 2 : NENT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  chk_idx,
    input  logic [1:0]        chk_acc,
    input  logic [1:0]        chk_priv,
    output logic              chk_fault
);
    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] cfg_d;
    logic [NENT-1:0]   lock_v, r_v, w_v, x_v;

    for (genvar i = 0; i < NENT; i++) begin : g_ent
        localparam logic LANE_OK = (i < ACTIVE);
        entry_t nxt_e;

        pmpc_legalize #(.GRAN(GRAN)) u_leg (
            .wr_ok (LANE_OK),
            .we    (wr_en),
            .cur   (entry_t'(cfg_q[i*ENT_W +: ENT_W])),
            .req   (entry_t'(wr_data[i*ENT_W +: ENT_W])),
            .nxt   (nxt_e)
        );

        assign cfg_d[i*ENT_W +: ENT_W] = nxt_e;
        assign lock_v[i] = cfg_q[i*ENT_W + B_LOCK];
        assign r_v[i]    = cfg_q[i*ENT_W + B_R];
        assign w_v[i]    = cfg_q[i*ENT_W + B_W];
        assign x_v[i]    = cfg_q[i*ENT_W + B_X];
    end

    pmpc_store #(.NENT(NENT), .ENT_W(ENT_W)) u_store (
        .clk (clk),
        .rst (rst),
        .nxt (cfg_d),
        .q   (cfg_q)
    );

    pmpc_perm #(.NENT(NENT)) u_perm (
        .lock_v (lock_v),
        .r_v    (r_v),
        .w_v    (w_v),
        .x_v    (x_v),
        .idx    (chk_idx),
        .acc    (chk_acc),
        .priv   (chk_priv),
        .fault  (chk_fault)
    );

    assign rd_data = cfg_q;
endmodule

// File: rtl/pmpc_cfg_chk.sv
module pmpc_cfg_chk #(
    parameter int XLEN = 64,
    parameter int GRAN = 2,
    parameter int NENT = 8,
    localparam int WORD_W = NENT * 8,
    localparam int IDX_W  = $clog2(NENT),
    localparam int ACTIVE = (XLEN == 32) ? NENT / 2 : NENT
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] rd_data,
    input logic [IDX_W-1:0]  chk_idx,
    input logic [1:0]        chk_acc,
    input logic [1:0]        chk_priv,
    input logic              chk_fault
);
    // R1: reset clears the word
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> rd_data == '0);

    // R10: machine access to an unlocked entry never faults
    a_r10_mach_open: assert property (@(posedge clk) disable iff (rst)
        (chk_priv == 2'd3 && !rd_data[{chk_idx, 3'd7}] && chk_acc != 2'd3) |-> !chk_fault);

    for (genvar i = 0; i < NENT; i++) begin : g_lane
        // R3: reserved bits read zero
        a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
            rd_data[i*8+5 +: 2] == 2'b00);

        // R4: the write-without-read pair is never held
        a_r4_no_wo_pair: assert property (@(posedge clk) disable iff (rst)
            !(!rd_data[i*8] && rd_data[i*8+1]));

        // R7: a locked byte holds its value
        a_r7_lock_hold: assert property (@(posedge clk) disable iff (rst)
            rd_data[i*8+7] |=> $stable(rd_data[i*8 +: 8]));

        if (GRAN >= 2) begin : g_coarse
            // R6: four-byte aligned mode never stored
            a_r6_no_na4: assert property (@(posedge clk) disable iff (rst)
                rd_data[i*8+3 +: 2] != 2'd2);
        end

        if (i >= ACTIVE) begin : g_narrow
            // R8: lanes above the register width stay clear
            a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
                rd_data[i*8 +: 8] == 8'h00);
        end else begin : g_wide
            // R11: a clean write to an unlocked byte lands one edge later
            a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
                (wr_en && !rd_data[i*8+7]
                 && !(!wr_data[i*8] && wr_data[i*8+1])
                 && !((GRAN >= 2) && wr_data[i*8+3 +: 2] == 2'd2))
                |=> rd_data[i*8 +: 8] == ($past(wr_data[i*8 +: 8]) & 8'h9F));
        end
    end
endmodule

bind pmpc_cfg_reg pmpc_cfg_chk #(.XLEN(XLEN), .GRAN(GRAN), .NENT(NENT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .chk_idx   (chk_idx),
    .chk_acc   (chk_acc),
    .chk_priv  (chk_priv),
    .chk_fault (chk_fault)
);

// File: tb/tb_pmpc_cfg_reg.sv
`timescale 1ns/1ps
module tb_pmpc_cfg_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [63:0] wr_data;
    logic [2:0]  idx;
    logic [1:0]  acc, priv;
    logic [63:0] rd64, rd32;
    logic        f64, f32;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic [7:0] m64 [8];
    logic [7:0] m32 [8];

    always #10 clk = ~clk;

    pmpc_cfg_reg #(.XLEN(64), .GRAN(2)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd64),
        .chk_idx(idx), .chk_acc(acc), .chk_priv(priv), .chk_fault(f64));

    pmpc_cfg_reg #(.XLEN(32), .GRAN(0)) dut32 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd32),
        .chk_idx(idx), .chk_acc(acc), .chk_priv(priv), .chk_fault(f32));

    function automatic logic [7:0] upd(logic [7:0] old, logic [7:0] nw, int gran, bit ok);
        if (!ok) return old;
        if (old[7]) return old;
        if (!nw[0] && nw[1]) return old;
        if (gran >= 2 && nw[4:3] == 2'd2) return old;
        return nw & 8'h9F;
    endfunction

    function automatic logic ref_fault(logic [7:0] e, logic [1:0] a, logic [1:0] p);
        if (p == 2'd3 && !e[7]) return 1'b0;
        case (a)
            2'd0:    return !e[0];
            2'd1:    return !e[1];
            2'd2:    return !e[2];
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [63:0] pack(logic [7:0] m [8]);
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = m[i];
        return v;
    endfunction

    // behavioural reference, advanced on every edge
    always @(posedge clk) begin
        for (int i = 0; i < 8; i++) begin
            if (rst) begin
                m64[i] <= 8'h00;
                m32[i] <= 8'h00;
            end else if (wr_en) begin
                m64[i] <= upd(m64[i], wr_data[i*8 +: 8], 2, 1'b1);
                m32[i] <= upd(m32[i], wr_data[i*8 +: 8], 0, i < 4);
            end
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({cur_req, " model wide"},   rd64, pack(m64));
            check({cur_req, " model narrow"}, rd32, pack(m32));
            check({cur_req, " fault wide"},   {63'd0, f64}, {63'd0, ref_fault(m64[idx], acc, priv)});
            check({cur_req, " fault narrow"}, {63'd0, f32}, {63'd0, ref_fault(m32[idx], acc, priv)});
        end
    end

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic wr(logic [63:0] v);
        wr_en = 1'b1;
        wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic query(string req, int i, int a, int p, bit exp64);
        idx = i[2:0]; acc = a[1:0]; priv = p[1:0];
        #2;
        check(req, {63'd0, f64}, {63'd0, exp64});
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; idx = '0; acc = '0; priv = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R1 reset wide", rd64, 64'h0);
        check("R1 reset narrow", rd32, 64'h0);

        cur_req = "R2";
        wr_en = 1'b1; wr_data = 64'h0F0D_1B19_0B09_0301;
        #2;
        check("R11 not before edge", rd64, 64'h0);
        tick(); wr_en = 1'b0;
        check("R2 legal word", rd64, 64'h0F0D_1B19_0B09_0301);
        check("R8 narrow upper zero", rd32, 64'h0000_0000_0B09_0301);

        cur_req = "R3";
        wr(64'h0F0D_1B19_0B09_0367);
        check("R3 reserved dropped", rd64, 64'h0F0D_1B19_0B09_0307);

        cur_req = "R4";
        wr(64'h0F0D_1B19_0B09_0B02);
        check("R4 R5 pair rejected neighbour taken", rd64, 64'h0F0D_1B19_0B09_0B07);

        cur_req = "R6";
        wr(64'h0F0D_1B19_0B11_0B07);
        check("R6 coarse rejects mode 2", rd64, 64'h0F0D_1B19_0B09_0B07);
        check("R6 fine accepts mode 2", rd32, 64'h0000_0000_0B11_0B07);

        cur_req = "R7";
        wr(64'h0F0D_1B19_8B11_0B07);
        check("R7 lock set", rd64, 64'h0F0D_1B19_8B09_0B07);
        wr(64'h0F0D_1B19_0F09_0B07);
        check("R7 locked byte unchanged", rd64, 64'h0F0D_1B19_8B09_0B07);
        check("R7 narrow locked", rd32, 64'h0000_0000_8B09_0B07);

        cur_req = "R9";
        query("R9 user load on read-only", 2, 0, 0, 1'b0);
        query("R9 user store on read-only", 2, 1, 0, 1'b1);
        query("R9 user fetch on read-only", 2, 2, 0, 1'b1);
        query("R9 user fetch no X", 1, 2, 0, 1'b1);
        query("R9 user store allowed", 1, 1, 0, 1'b0);
        query("R9 reserved access code", 0, 3, 1, 1'b1);
        query("R9 supervisor fetch with X", 6, 2, 1, 1'b0);

        cur_req = "R10";
        query("R10 machine unlocked store", 2, 1, 3, 1'b0);
        query("R10 machine locked fetch", 3, 2, 3, 1'b1);
        query("R10 machine locked store", 3, 1, 3, 1'b0);

        cur_req = "R8";
        idx = 3'd5; acc = 2'd0; priv = 2'd0;
        #2;
        check("R8 narrow lane 5 faults", {63'd0, f32}, 64'd1);

        cur_req = "R1";
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R1 reset clears lock", rd64, 64'h0);
        tick();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4_000_000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule